// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Controller

This block sits beside a real-time clock's timekeeping counters and decides when the clock raises its single interrupt line. It compares the current BCD seconds, minutes, hours and date against four programmed alarm values. Each field carries a skip bit: a field with its skip bit at 0 takes part in the comparison, and a field with its skip bit at 1 is ignored. The comparison is made only on the cycle the timekeeping logic strobes a seconds update. When every participating field matches, the alarm flag is set. If all four fields are skipped, no alarm is ever produced.

Three sticky flags share one interrupt output: the alarm flag, a watchdog-expiry flag and a power-fail flag. The last two are set from event inputs. Each flag reaches the interrupt only through its own enable bit. The output polarity can be selected. The output can either hold its level until software reads the flag register, or give a fixed-length pulse for each enabled set event. A read strobe of the flag register clears all three flags. Until the power-up recall period is over, the block ignores every event and holds the interrupt output inactive.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The packed fields of `cur_time_i` and `alm_val_i` are laid out with seconds in bits [7:0], minutes in [15:8], hours in [23:16] and date in [31:24]. Bit k of `alm_skip_i` excludes field k when it is 1. On a seconds strobe, the alarm flag `flags_o[0]` sets when every field with skip bit 0 is equal.
- R2: When `alm_skip_i` is 4'b1111, a seconds strobe never sets the alarm flag.
- R3: The comparison is made only in a cycle with `sec_tick_i` high. The alarm flag becomes visible on the cycle after the strobe. Matching values without a strobe have no effect.
- R4: A `wdog_evt_i` pulse sets `flags_o[1]`, and a `pfail_evt_i` pulse sets `flags_o[2]`. Each flag is visible one cycle after its pulse, whatever the enable bits hold.
- R5: A cycle with `flag_rd_i` high clears all flags on the next cycle. A set event in the same cycle as the read wins, so that flag stays 1.
- R6: Flag k drives the interrupt only when `irq_en_i[k]` is 1, using the same bit order as `flags_o`.
- R7: In level mode (`irq_pulse_i` = 0), the interrupt is active while any enabled flag is set. It goes inactive on the cycle after a clearing read.
- R8: In pulse mode (`irq_pulse_i` = 1), every enabled set event makes the interrupt active for exactly PULSE_CYC cycles, starting on the cycle after the event. A new event restarts the count.
- R9: With `irq_act_high_i` = 1 the active level of `irq_o` is 1. With `irq_act_high_i` = 0 the active level is 0.
- R10: While `init_done_i` is 0, the seconds strobe and both event inputs leave the flags unchanged, and `irq_o` sits at its inactive level.
- R11: After reset all flags are 0 and `irq_o` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | High once the power-up recall period is over |
| sec_tick_i | input | 1 | One-cycle strobe for each seconds update |
| cur_time_i | input | 32 | Current date, hours, minutes and seconds (BCD) |
| alm_val_i | input | 32 | Alarm date, hours, minutes and seconds (BCD) |
| alm_skip_i | input | 4 | Per-field skip bits; 1 excludes the field |
| wdog_evt_i | input | 1 | Watchdog expiry event |
| pfail_evt_i | input | 1 | Power-fail event |
| irq_en_i | input | 3 | Interrupt enables for {power-fail, watchdog, alarm} |
| irq_pulse_i | input | 1 | 1 selects pulse mode, 0 selects level mode |
| irq_act_high_i | input | 1 | 1 selects an active-high interrupt |
| flag_rd_i | input | 1 | Read strobe of the flag register; clears the flags |
| flags_o | output | 3 | Flags {power-fail, watchdog, alarm} |
| irq_o | output | 1 | Interrupt output |

## Verification
Every flag and every pulse start is registered once. The result of a strobe, event or read driven in one cycle is therefore due one cycle later. The bench drives inputs on the falling edge and samples on the next falling edge, so it sees exactly that cycle. In level mode the interrupt follows the flag registers through logic only, so the bench checks it in the same sample as the flag. Pulse length is measured by counting the falling-edge samples in which the output is active, starting with the first sample after the event. The bench sweeps all 16 skip masks against all 16 patterns of mismatching fields.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned SRC_ALM  = 0;
  localparam int unsigned SRC_WDOG = 1;
  localparam int unsigned SRC_PF   = 2;

  typedef struct packed {
    logic act_high;
    logic pulse;
  } irq_cfg_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NUM_FIELDS = 4,
  parameter int unsigned FIELD_W    = 8
) (
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cur_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alm_i,
  input  logic [NUM_FIELDS-1:0]         skip_i,
  output logic                          hit_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    assign fld_ok[k] = skip_i[k] |
                       (cur_i[k*FIELD_W +: FIELD_W] == alm_i[k*FIELD_W +: FIELD_W]);
  end

  // a fully skipped alarm never fires
  assign hit_o = tick_i & ~(&skip_i) & (&fld_ok);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (clr_i ? '0 : flags_o) | set_i;
  end

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> flags_o == '0); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R5
endmodule

// File: rtl/rtc_irq_shaper.sv
module rtc_irq_shaper
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 3,
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  irq_cfg_t           cfg_i,
  output logic               irq_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;
  logic          trig;
  logic          lvl_act;
  logic          active;

  assign trig    = arm_i & |(set_i & en_i);
  assign lvl_act = |(flags_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!arm_i)        cnt_q <= '0;
    else if (trig)          cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = arm_i & (cfg_i.pulse ? (cnt_q != '0) : lvl_act);
  assign irq_o  = cfg_i.act_high ? active : ~active;

  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD); // R8

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && cfg_i.pulse) |=> (!arm_i || !cfg_i.pulse || irq_o == cfg_i.act_high)); // R8

  AST_INIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> irq_o == !cfg_i.act_high); // R10
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 4,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned PULSE_CYC  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_done_i,
  input  logic                          sec_tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alm_val_i,
  input  logic [NUM_FIELDS-1:0]         alm_skip_i,
  input  logic                          wdog_evt_i,
  input  logic                          pfail_evt_i,
  input  logic [NUM_SRC-1:0]            irq_en_i,
  input  logic                          irq_pulse_i,
  input  logic                          irq_act_high_i,
  input  logic                          flag_rd_i,
  output logic [NUM_SRC-1:0]            flags_o,
  output logic                          irq_o
);
  logic               alm_hit;
  logic [NUM_SRC-1:0] set_vec;
  irq_cfg_t           cfg;

  rtc_alarm_cmp #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W)
  ) u_cmp (
    .tick_i (sec_tick_i & init_done_i),
    .cur_i  (cur_time_i),
    .alm_i  (alm_val_i),
    .skip_i (alm_skip_i),
    .hit_o  (alm_hit)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_ALM]  = alm_hit;
    set_vec[SRC_WDOG] = wdog_evt_i & init_done_i;
    set_vec[SRC_PF]   = pfail_evt_i & init_done_i;
  end

  rtc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (flag_rd_i),
    .flags_o (flags_o)
  );

  assign cfg.act_high = irq_act_high_i;
  assign cfg.pulse    = irq_pulse_i;

  rtc_irq_shaper #(
    .NUM_SRC   (NUM_SRC),
    .PULSE_CYC (PULSE_CYC)
  ) u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (init_done_i),
    .flags_i (flags_o),
    .set_i   (set_vec),
    .en_i    (irq_en_i),
    .cfg_i   (cfg),
    .irq_o   (irq_o)
  );

  AST_ALARM_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[SRC_ALM]) |-> $past(sec_tick_i)); // R3

  AST_ALL_SKIPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alm_skip_i && !flags_o[SRC_ALM]) |=> !flags_o[SRC_ALM]); // R2

  AST_INIT_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_i && flags_o == '0) |=> flags_o == '0); // R10
endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  localparam int PULSE = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_done_i = 1'b0;
  logic        sec_tick_i = 1'b0;
  logic [31:0] cur_time_i = '0;
  logic [31:0] alm_val_i = '0;
  logic [3:0]  alm_skip_i = '0;
  logic        wdog_evt_i = 1'b0;
  logic        pfail_evt_i = 1'b0;
  logic [2:0]  irq_en_i = '0;
  logic        irq_pulse_i = 1'b0;
  logic        irq_act_high_i = 1'b1;
  logic        flag_rd_i = 1'b0;
  logic [2:0]  flags_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rtc_alarm_irq #(.PULSE_CYC(PULSE)) u_rtc_alarm_irq (
    .clk_i, .rst_ni, .init_done_i, .sec_tick_i, .cur_time_i, .alm_val_i,
    .alm_skip_i, .wdog_evt_i, .pfail_evt_i, .irq_en_i, .irq_pulse_i,
    .irq_act_high_i, .flag_rd_i, .flags_o, .irq_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic idle_lvl();
    return !irq_act_high_i;
  endfunction

  task automatic tick();
    @(negedge clk_i) sec_tick_i = 1'b1;
    @(negedge clk_i) sec_tick_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk_i) flag_rd_i = 1'b1;
    @(negedge clk_i) flag_rd_i = 1'b0;
  endtask

  task automatic count_active(output int n);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (irq_o == irq_act_high_i) n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    int n;
    logic [31:0] base;
    base = 32'h2823_5945;

    // R11 reset state
    #1;
    chk("R11 flags", flags_o, 3'b000);
    chk("R11 irq", irq_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 events before init are ignored
    cur_time_i = base; alm_val_i = base; alm_skip_i = 4'b0000;
    irq_en_i = 3'b111; irq_act_high_i = 1'b1;
    tick();
    @(negedge clk_i) begin wdog_evt_i = 1'b1; pfail_evt_i = 1'b1; end
    @(negedge clk_i) begin wdog_evt_i = 1'b0; pfail_evt_i = 1'b0; end
    chk("R10 flags", flags_o, 3'b000);
    chk("R10 irq", irq_o, 1'b0);
    init_done_i = 1'b1;
    irq_en_i = 3'b000;

    // R3 matching values without a strobe
    repeat (3) @(negedge clk_i);
    chk("R3 no tick", flags_o, 3'b000);

    // R1 R2 sweep: skip mask x mismatching-field pattern
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 16; d++) begin
        logic exp;
        alm_val_i = base;
        alm_skip_i = 4'(m);
        for (int k = 0; k < 4; k++)
          cur_time_i[k*8 +: 8] = base[k*8 +: 8] ^ (d[k] ? 8'h01 : 8'h00);
        exp = (m != 15) && ((d & ~m & 15) == 0);
        tick();
        chk((m == 15) ? "R2 all skipped" : "R1 match", flags_o[0], exp);
        chk("R6 disabled irq", irq_o, 1'b0);
        rd();
        chk("R5 cleared", flags_o, 3'b000);
      end
    end

    // R4 event flags, no enables
    @(negedge clk_i) wdog_evt_i = 1'b1;
    @(negedge clk_i) wdog_evt_i = 1'b0;
    chk("R4 wdog", flags_o, 3'b010);
    @(negedge clk_i) pfail_evt_i = 1'b1;
    @(negedge clk_i) pfail_evt_i = 1'b0;
    chk("R4 pfail", flags_o, 3'b110);
    chk("R6 no enable", irq_o, 1'b0);

    // R6 R7 level mode: enable only pfail
    irq_en_i = 3'b100;
    @(negedge clk_i);
    chk("R7 level on", irq_o, 1'b1);
    rd();
    chk("R7 level off", irq_o, 1'b0);

    // R5 set and read in the same cycle
    @(negedge clk_i) begin wdog_evt_i = 1'b1; flag_rd_i = 1'b1; end
    @(negedge clk_i) begin wdog_evt_i = 1'b0; flag_rd_i = 1'b0; end
    chk("R5 set wins", flags_o, 3'b010);
    rd();

    // R7 alarm held until read
    irq_en_i = 3'b001;
    cur_time_i = base; alm_val_i = base; alm_skip_i = 4'b0000;
    tick();
    chk("R7 alarm level", irq_o, 1'b1);
    repeat (5) @(negedge clk_i);
    chk("R7 level held", irq_o, 1'b1);
    rd();
    chk("R7 level cleared", irq_o, 1'b0);

    // R9 active low
    irq_act_high_i = 1'b0;
    @(negedge clk_i);
    chk("R9 idle high", irq_o, 1'b1);
    tick();
    chk("R9 active low", irq_o, 1'b0);
    rd();
    chk("R9 back idle", irq_o, idle_lvl());

    // R8 pulse mode, both polarities
    irq_pulse_i = 1'b1;
    for (int p = 0; p < 2; p++) begin
      irq_act_high_i = p[0];
      tick();
      count_active(n);
      chk("R8 pulse length", n, PULSE);
      chk("R8 flag stays", flags_o[0], 1'b1);
      rd();
    end

    // R8 restart on a second event
    irq_act_high_i = 1'b1;
    irq_en_i = 3'b010;
    @(negedge clk_i) wdog_evt_i = 1'b1;
    @(negedge clk_i) wdog_evt_i = 1'b0;
    @(negedge clk_i) wdog_evt_i = 1'b1;
    @(negedge clk_i) wdog_evt_i = 1'b0;
    count_active(n);
    chk("R8 restart", n, PULSE);
    rd();

    // R6 pulse not started by disabled source
    @(negedge clk_i) pfail_evt_i = 1'b1;
    @(negedge clk_i) pfail_evt_i = 1'b0;
    count_active(n);
    chk("R6 disabled pulse", n, 0);

    // R10 init drop forces inactive
    irq_pulse_i = 1'b0;
    irq_en_i = 3'b100;
    @(negedge clk_i);
    chk("R10 pre", irq_o, 1'b1);
    init_done_i = 1'b0;
    @(negedge clk_i);
    chk("R10 inactive", irq_o, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule